// File: doc/BRIEF.md
# Synthesizer Serial Loader

This block lets a host controller program up to three external frequency synthesizers through one shared serial data line and one shared serial clock line. Each synthesizer has its own latch-enable line. The host writes a 32-bit word into four byte registers and then sets the loader up through three control registers. Writing the third control register starts one programming frame. That frame shifts out up to 31 bits and pulses the chosen latch enables. A word longer than 31 bits is sent as several frames, and only the last frame enables a latch.

A frame always lasts 32 ticks, and each tick takes two system clock cycles. In the first half of a tick the serial clock sits at its inactive level and the data bit for that tick is presented. In the second half the serial clock goes to its active level, so the data is stable on the active edge. A 5-bit tick count is compared against two programmable values. One comparison sets the latch flop and the other clears it. The `ready` output is low for the whole frame, and any write made while it is low is ignored.

Top module: `synth_loader`

## Requirements
- R1: After reset, `ready`=1, `serClk`=0, `serData`=0 and `latchEn`=0.
- R2: A write to address 6 while `ready`=1 starts a frame. `ready` is low from the next cycle for exactly 64 system cycles (32 ticks of 2 cycles each) and then returns high.
- R3: Address 6 holds the clock count N in bits 4:0 and the clock polarity P in bit 5. In tick t, `serClk` equals P in the first half. In the second half it equals ~P when t<N and stays at P otherwise. While idle, `serClk` equals P.
- R4: Addresses 0..3 hold bytes 0..3 of a word W, with address 0 as the least significant byte. When address 5 bit 5 is 0 (LSB first), tick t with t<N carries W[t] on `serData`.
- R5: When address 5 bit 5 is 1 (MSB first), tick t with t<N carries W[N-1-t].
- R6: `serData` holds the same value through both halves of a tick. It is 0 for ticks with t>=N and while idle.
- R7: Address 4 bits 7:5 are a select mask. Bit i allows `latchEn[i]`, and unselected lines stay 0.
- R8: Address 5 bits 4:0 are the set tick H and address 4 bits 4:0 are the clear tick L. The internal latch state becomes 1 in the second half of tick H and 0 in the second half of tick L. Clear wins when H equals L. The state is forced to 0 when the frame ends.
- R9: Writes to any address while `ready`=0 are ignored. This includes a new start and changes to the data, select or polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address (0..6) |
| wrData | input | 8 | Register write data |
| ready | output | 1 | High when no frame is in progress |
| serClk | output | 1 | Shared serial clock |
| serData | output | 1 | Shared serial data |
| latchEn | output | 3 | Per-synthesizer latch enables |

## Verification
Some properties are checked by the assertions on every cycle. The lines stay quiet while idle. A frame ends one cycle after the last tick's active half. `ready` can only fall after a start write. The data bit does not move between the two halves of a tick. The configuration does not change while a frame runs. Other behaviour can only be shown by the bench's directed frames, which compare outputs against a reference model sample by sample. These cover bit ordering in both directions, clock polarity, the exact ticks where the latch window opens and closes (including equal and reversed set/clear values and a zero clock count), and whether writes during a frame really leave the next frame unchanged.

// File: rtl/synth_loader_pkg.sv
package synth_loader_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int TICK_W     = $clog2(WORD_W);
  localparam int ADDR_W     = 3;
  localparam logic [ADDR_W-1:0] SEL_ADDR   = 3'd4;
  localparam logic [ADDR_W-1:0] ORDER_ADDR = 3'd5;
  localparam logic [ADDR_W-1:0] START_ADDR = 3'd6;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic              busy;
    logic              phase;   // 0: inactive half, 1: active half
    logic [TICK_W-1:0] tick;
  } ldStrobe_t;
endpackage

// File: rtl/synth_loader_ctrl.sv
module synth_loader_ctrl
  import synth_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startReq,
  input  logic [TICK_W-1:0] highVal,
  input  logic [TICK_W-1:0] lowVal,
  output ldStrobe_t         strobe,
  output logic              latchOn
);
  logic              busy;
  logic              phase;
  logic [TICK_W-1:0] tick;
  logic              lastHalf;

  assign lastHalf = busy && phase && (tick == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= 1'b0;
      tick  <= '0;
    end else if (!busy) begin
      busy  <= startReq;
      phase <= 1'b0;
      tick  <= '0;
    end else begin
      phase <= ~phase;
      if (phase) begin
        tick <= tick + 1'b1;
        if (tick == '1) busy <= 1'b0;
      end
    end
  end

  // set/reset latch flop: clear has priority, forced low at frame end
  always_ff @(posedge clk) begin
    if (!rst_n)                  latchOn <= 1'b0;
    else if (!busy || lastHalf)  latchOn <= 1'b0;
    else if (!phase) begin
      if (tick == lowVal)        latchOn <= 1'b0;
      else if (tick == highVal)  latchOn <= 1'b1;
    end
  end

  assign strobe = '{busy: busy, phase: phase, tick: tick};

  a_r2_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    lastHalf |=> !busy);
  a_r2_tick_order: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !phase) |=> (busy && phase && $stable(tick)));
  a_r8_latch_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !phase && tick == lowVal) |=> !latchOn);
endmodule

// File: rtl/synth_loader_regs.sv
module synth_loader_regs
  import synth_loader_pkg::*;
#(
  parameter int NUM_LE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  ldStrobe_t         strobe,
  input  logic              latchOn,
  output logic              startReq,
  output logic [TICK_W-1:0] highVal,
  output logic [TICK_W-1:0] lowVal,
  output logic [NUM_LE-1:0] selMask,
  output logic              serClk,
  output logic              serData,
  output logic [NUM_LE-1:0] latchEn
);
  logic [7:0]        dataByte [WORD_BYTES];
  logic [WORD_W-1:0] word;
  logic [7:0]        selReg, orderReg, startReg;
  logic              wrOk;
  logic [TICK_W-1:0] numClks;
  logic              clkPol, msbFirst, inRange;
  logic [TICK_W-1:0] bitIdx;

  assign wrOk     = wrEn && !strobe.busy;
  assign startReq = wrOk && (wrAddr == START_ADDR);

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)                                  dataByte[b] <= '0;
      else if (wrOk && wrAddr == ADDR_W'(b))       dataByte[b] <= wrData;
    end
    assign word[8*b +: 8] = dataByte[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selReg   <= '0;
      orderReg <= '0;
      startReg <= '0;
    end else if (wrOk) begin
      if (wrAddr == SEL_ADDR)   selReg   <= wrData;
      if (wrAddr == ORDER_ADDR) orderReg <= wrData;
      if (wrAddr == START_ADDR) startReg <= wrData;
    end
  end

  assign lowVal   = selReg[TICK_W-1:0];
  assign selMask  = selReg[7 -: NUM_LE];
  assign highVal  = orderReg[TICK_W-1:0];
  assign msbFirst = orderReg[5];
  assign numClks  = startReg[TICK_W-1:0];
  assign clkPol   = startReg[5];

  assign inRange = strobe.busy && (strobe.tick < numClks);
  assign bitIdx  = msbFirst ? (numClks - 1'b1 - strobe.tick) : strobe.tick;
  assign serData = inRange ? word[bitIdx] : 1'b0;
  assign serClk  = clkPol ^ (inRange && strobe.phase);
  assign latchEn = latchOn ? selMask : '0;

  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.busy |=> ($stable(selReg) && $stable(orderReg) && $stable(startReg)
                     && $stable(word)));
  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.busy && !strobe.phase) |=> $stable(serData));
endmodule

// File: rtl/synth_loader.sv
module synth_loader
  import synth_loader_pkg::*;
#(
  parameter int NUM_LE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output logic              ready,
  output logic              serClk,
  output logic              serData,
  output logic [NUM_LE-1:0] latchEn
);
  ldStrobe_t         strobe;
  logic              startReq;
  logic              latchOn;
  logic [TICK_W-1:0] highVal, lowVal;
  logic [NUM_LE-1:0] selMask;

  synth_loader_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .startReq(startReq),
    .highVal(highVal), .lowVal(lowVal),
    .strobe(strobe), .latchOn(latchOn)
  );

  synth_loader_regs #(.NUM_LE(NUM_LE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .latchOn(latchOn), .startReq(startReq),
    .highVal(highVal), .lowVal(lowVal), .selMask(selMask),
    .serClk(serClk), .serData(serData), .latchEn(latchEn)
  );

  assign ready = !strobe.busy;

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (serData == 1'b0 && latchEn == '0));
  a_r2_start_only: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(wrEn && wrAddr == START_ADDR));
  a_r7_mask_only: assert property (@(posedge clk) disable iff (!rst_n)
    (latchEn & ~selMask) == '0);
endmodule

// File: tb/tb_synth_loader.sv
module tb_synth_loader;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       ready, serClk, serData;
  logic [2:0] latchEn;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  synth_loader dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ready(ready), .serClk(serClk), .serData(serData), .latchEn(latchEn)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runFrame(input logic [31:0] word, input logic [2:0] sel,
                          input int lo, input int hi, input bit msb, input bit pol,
                          input int n, input bit loadRegs, input bit busyPoke);
    bit on = 1'b0;
    if (loadRegs) begin
      for (int b = 0; b < 4; b++) wr(3'(b), word[8*b +: 8]);
      wr(3'd4, {sel, 5'(lo)});
      wr(3'd5, {2'b00, msb, 5'(hi)});
    end
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd6; wrData = {2'b00, pol, 5'(n)};
    @(negedge clk);
    wrEn = 1'b0;
    for (int k = 0; k < 64; k++) begin
      int t = k / 2;
      bit ph = k[0];
      int idx = msb ? (n - 1 - t) : t;
      bit expD = (t < n) ? word[idx] : 1'b0;
      bit expC = pol ^ (ph && (t < n));
      if (ph && t == lo) on = 1'b0;
      else if (ph && t == hi) on = 1'b1;
      check("R2", "ready during frame", ready, 0);
      check("R3", "serClk", serClk, expC);
      check(msb ? "R5" : "R4", "serData", serData, expD);
      check("R8", "latchEn", latchEn, on ? sel : 3'b000);
      if (busyPoke) begin
        if (k == 9)  begin wrEn = 1'b1; wrAddr = 3'd0; wrData = ~word[7:0]; end
        if (k == 10) begin wrAddr = 3'd4; wrData = {~sel, 5'(lo)}; end
        if (k == 11) begin wrAddr = 3'd6; wrData = {2'b00, ~pol, 5'(n)}; end
        if (k == 12) wrEn = 1'b0;
      end
      @(negedge clk);
    end
    check("R2", "ready after 64 cycles", ready, 1);
    check("R6", "idle serData", serData, 0);
    check("R3", "idle serClk", serClk, pol);
    check("R8", "latch cleared at end", latchEn, 0);
  endtask

  task automatic testReset();
    check("R1", "reset ready", ready, 1);
    check("R1", "reset serClk", serClk, 0);
    check("R1", "reset serData", serData, 0);
    check("R1", "reset latchEn", latchEn, 0);
  endtask

  // R4 R7 R8: LSB first, window inside the frame
  task automatic testLsbWindow();
    runFrame(32'hA5C3_0F96, 3'b001, 26, 24, 1'b0, 1'b0, 24, 1'b1, 1'b0);
  endtask

  // R5 R3 R8: MSB first, inverted clock, equal set/clear never opens
  task automatic testMsbEqual();
    runFrame(32'h1234_5678, 3'b100, 3, 3, 1'b1, 1'b1, 31, 1'b1, 1'b0);
  endtask

  // R3 R8 R7: zero clocks, set after clear, held until frame end, two lines
  task automatic testNoClocks();
    runFrame(32'hFFFF_FFFF, 3'b110, 2, 10, 1'b0, 1'b0, 0, 1'b1, 1'b0);
  endtask

  // R9: writes during a frame change nothing in this or the next frame
  task automatic testBusyWrites();
    runFrame(32'h00F0_3C81, 3'b010, 20, 5, 1'b1, 1'b0, 13, 1'b1, 1'b1);
    runFrame(32'h00F0_3C81, 3'b010, 20, 5, 1'b1, 1'b0, 13, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testLsbWindow();
    testMsbEqual();
    testNoClocks();
    testBusyWrites();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule